// File: doc/BRIEF.md
# Transceiver Mode-Change Request Sequencer

This block collects mode-change requests from a group of transceiver channels. Each request carries the configuration mode the channel wants. When the shared reconfiguration engine is idle and both transmit and receive datapaths report ready, a fixed-priority arbiter picks one requester. The block then raises that channel's acknowledge and keeps it raised until the whole change is finished. The requester is expected to drop its request once it sees the acknowledge.

While the acknowledge is held, the block sequences the external engine. It presents the channel index and enables image streaming. It selects the configuration image that matches the mode captured at grant time and issues a single start pulse. It treats the change as complete only after the engine's busy line has gone high and then low. It then pulses the digital reset of the reconfigured channel for a fixed number of cycles and waits for the link to report up before it releases the acknowledge. A watchdog returns the block to idle and sets a sticky error flag if the engine or the link stalls.

Top module: `recfg_sequencer`

## Requirements
- R1: A request is granted only in a cycle where `eng_busy` is low and both `xcvr_tx_rdy` and `xcvr_rx_rdy` are high. Otherwise `chan_ack` stays all zero.
- R2: Among simultaneous requests, the lowest channel index wins. `chan_ack` is one-hot (bit n = channel n) and names only the granted channel. Requests are sampled only while idle, so a request raised mid-sequence does not change `chan_ack` and is served at the next idle.
- R3: From the cycle the acknowledge first appears until the sequence ends, `eng_chan` carries the granted channel number, `eng_img_sel` carries that channel's mode (mode field n is `chan_mode[n*MW +: MW]`), and `eng_stream_en` is high.
- R4: `eng_start` is high for exactly one cycle: the cycle right after the acknowledge first becomes visible.
- R5: A busy line that stays low after the start pulse does not count as completion, and no digital reset is issued.
- R6: One cycle after `eng_busy` falls (having first risen), `chan_drst` carries the one-hot bit of the granted channel for exactly RST_CYC consecutive cycles.
- R7: After the reset pulse, `chan_ack` stays asserted until `link_up` is sampled high. It clears one cycle later.
- R8: The mode is captured at grant time. A change on the channel's mode input later in the sequence does not change `eng_img_sel`.
- R9: If the watchdog limit WDOG expires while waiting for busy to rise, busy to fall or the link to come up, the block returns to idle, clears `chan_ack` and sets `seq_err`. `seq_err` stays set until reset. From a start pulse with busy never rising, the acknowledge disappears WDOG+2 cycles after it first appeared.
- R10: While `rst` is high, `chan_ack`, `eng_start`, `eng_stream_en`, `chan_drst` and `seq_err` are all low, whatever the requests are.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| chan_req | input | NCH | Per-channel mode-change request |
| chan_mode | input | NCH*MW | Requested mode per channel, field n at bits n*MW |
| chan_ack | output | NCH | One-hot acknowledge, held for the whole sequence |
| xcvr_tx_rdy | input | 1 | Transmit datapath ready |
| xcvr_rx_rdy | input | 1 | Receive datapath ready |
| link_up | input | 1 | Link ready after digital reset |
| eng_busy | input | 1 | Reconfiguration engine busy |
| eng_chan | output | CHW | Channel number presented to the engine |
| eng_stream_en | output | 1 | Engine placed in image-streaming mode |
| eng_img_sel | output | MW | Configuration image select |
| eng_start | output | 1 | One-cycle stream start |
| chan_drst | output | NCH | One-hot per-channel digital reset |
| seq_err | output | 1 | Sticky watchdog error |

## Verification
A wrong sequencer state shows up quickly at the ports. It appears as a start pulse that is missing or doubled the cycle after the acknowledge. It can also appear as a reset pulse that comes while busy never rose, or whose length differs from RST_CYC. A third sign is an acknowledge that drops before the link is up. A bad priority or capture register shows up in the first cycle of the acknowledge: the wrong one-hot bit, channel number or image select. A watchdog fault shows up as an acknowledge release that misses WDOG+2 by even one cycle.

// File: rtl/recfg_pkg.sv
package recfg_pkg;

    typedef enum logic [2:0] {
        S_IDLE,
        S_SETUP,
        S_START,
        S_WAIT_HI,
        S_WAIT_LO,
        S_DRST,
        S_WAIT_LINK
    } seq_state_t;

    // States in which the watchdog runs
    function automatic logic is_watched(input seq_state_t s);
        return (s == S_WAIT_HI) || (s == S_WAIT_LO) || (s == S_WAIT_LINK);
    endfunction

endpackage

// File: rtl/recfg_prio_arb.sv
module recfg_prio_arb #(
    parameter int NCH = 4,
    localparam int IW = (NCH > 1) ? $clog2(NCH) : 1
) (
    input  logic [NCH-1:0] req,
    output logic           any,
    output logic [IW-1:0]  idx,
    output logic [NCH-1:0] gnt
);

    // lowest index wins: scan from the top so the last hit is the lowest
    always_comb begin
        gnt = '0;
        idx = '0;
        for (int i = NCH - 1; i >= 0; i--) begin
            if (req[i]) begin
                gnt    = '0;
                gnt[i] = 1'b1;
                idx    = IW'(i);
            end
        end
        any = |req;
    end

endmodule

// File: rtl/recfg_tick.sv
module recfg_tick #(
    parameter int LIMIT = 8,
    localparam int CW = $clog2(LIMIT + 1)
) (
    input  logic clk,
    input  logic rst,
    input  logic clr,
    input  logic en,
    output logic hit
);

    logic [CW-1:0] cnt;

    assign hit = en && (cnt == CW'(LIMIT - 1));

    always_ff @(posedge clk) begin
        if (rst || clr)
            cnt <= '0;
        else if (en)
            cnt <= hit ? '0 : cnt + CW'(1);
    end

    AST_TICK_RANGE: assert property (@(posedge clk) disable iff (rst)
        cnt < CW'(LIMIT)) else $error("tick counter beyond limit"); // R6

endmodule

// File: rtl/recfg_sequencer.sv
module recfg_sequencer
    import recfg_pkg::*;
#(
    parameter int NCH     = 4,
    parameter int NMODE   = 2,
    parameter int RST_CYC = 8,
    parameter int WDOG    = 4096,
    localparam int CHW = (NCH > 1) ? $clog2(NCH) : 1,
    localparam int MW  = (NMODE > 1) ? $clog2(NMODE) : 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [NCH-1:0]    chan_req,
    input  logic [NCH*MW-1:0] chan_mode,
    output logic [NCH-1:0]    chan_ack,
    input  logic              xcvr_tx_rdy,
    input  logic              xcvr_rx_rdy,
    input  logic              link_up,
    input  logic              eng_busy,
    output logic [CHW-1:0]    eng_chan,
    output logic              eng_stream_en,
    output logic [MW-1:0]     eng_img_sel,
    output logic              eng_start,
    output logic [NCH-1:0]    chan_drst,
    output logic              seq_err
);

    seq_state_t     st_q, st_d;
    logic [CHW-1:0] ch_q;
    logic [MW-1:0]  md_q;
    logic [NCH-1:0] ack_q;
    logic           err_q;
    logic           tmo;

    logic           arb_any;
    logic [CHW-1:0] arb_idx;
    logic [NCH-1:0] arb_gnt;
    logic           sys_ready;
    logic           st_chg;
    logic           pulse_hit;
    logic           wd_hit;

    assign sys_ready = !eng_busy && xcvr_tx_rdy && xcvr_rx_rdy;
    assign st_chg    = (st_d != st_q);

    recfg_prio_arb #(.NCH(NCH)) u_arb (
        .req (chan_req),
        .any (arb_any),
        .idx (arb_idx),
        .gnt (arb_gnt)
    );

    recfg_tick #(.LIMIT(RST_CYC)) u_pulse (
        .clk (clk),
        .rst (rst),
        .clr (st_chg),
        .en  (st_q == S_DRST),
        .hit (pulse_hit)
    );

    recfg_tick #(.LIMIT(WDOG)) u_wdog (
        .clk (clk),
        .rst (rst),
        .clr (st_chg),
        .en  (is_watched(st_q)),
        .hit (wd_hit)
    );

    always_comb begin
        st_d = st_q;
        tmo  = 1'b0;
        unique case (st_q)
            S_IDLE:      if (sys_ready && arb_any) st_d = S_SETUP;
            S_SETUP:     st_d = S_START;
            S_START:     st_d = S_WAIT_HI;
            S_WAIT_HI: begin
                if (eng_busy)    st_d = S_WAIT_LO;
                else if (wd_hit) begin st_d = S_IDLE; tmo = 1'b1; end
            end
            S_WAIT_LO: begin
                if (!eng_busy)   st_d = S_DRST;
                else if (wd_hit) begin st_d = S_IDLE; tmo = 1'b1; end
            end
            S_DRST:      if (pulse_hit) st_d = S_WAIT_LINK;
            S_WAIT_LINK: begin
                if (link_up)     st_d = S_IDLE;
                else if (wd_hit) begin st_d = S_IDLE; tmo = 1'b1; end
            end
            default:     st_d = S_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q  <= S_IDLE;
            ch_q  <= '0;
            md_q  <= '0;
            ack_q <= '0;
            err_q <= 1'b0;
        end else begin
            st_q <= st_d;
            if (st_q == S_IDLE && st_d == S_SETUP) begin
                ack_q <= arb_gnt;
                ch_q  <= arb_idx;
                md_q  <= chan_mode[arb_idx*MW +: MW];
            end else if (st_q != S_IDLE && st_d == S_IDLE) begin
                ack_q <= '0;
            end
            if (tmo)
                err_q <= 1'b1;
        end
    end

    assign chan_ack      = ack_q;
    assign eng_chan      = ch_q;
    assign eng_img_sel   = md_q;
    assign eng_stream_en = (st_q != S_IDLE);
    assign eng_start     = (st_q == S_START);
    assign chan_drst     = (st_q == S_DRST) ? (NCH'(1) << ch_q) : '0;
    assign seq_err       = err_q;

    AST_GRANT_WHEN_READY: assert property (@(posedge clk) disable iff (rst)
        $rose(|chan_ack) |-> $past(!eng_busy && xcvr_tx_rdy && xcvr_rx_rdy))
        else $error("grant while system not ready"); // R1
    AST_ACK_ONEHOT: assert property (@(posedge clk) disable iff (rst)
        $onehot0(chan_ack)) else $error("acknowledge not one-hot"); // R2
    AST_START_ACKED: assert property (@(posedge clk) disable iff (rst)
        eng_start |-> (chan_ack == (NCH'(1) << eng_chan)))
        else $error("start without matching acknowledge"); // R3
    AST_START_SINGLE: assert property (@(posedge clk) disable iff (rst)
        eng_start |=> !eng_start) else $error("start longer than one cycle"); // R4
    AST_DRST_OWNER: assert property (@(posedge clk) disable iff (rst)
        (|chan_drst) |-> (chan_drst == chan_ack))
        else $error("reset on a channel not acknowledged"); // R6
    AST_ACK_RELEASE: assert property (@(posedge clk) disable iff (rst)
        $fell(|chan_ack) |-> $past(link_up || wd_hit))
        else $error("acknowledge released early"); // R7
    AST_IMG_STABLE: assert property (@(posedge clk) disable iff (rst)
        (eng_stream_en && $past(eng_stream_en)) |-> $stable(eng_img_sel))
        else $error("image select changed mid-sequence"); // R8
    AST_ERR_STICKY: assert property (@(posedge clk) disable iff (rst)
        seq_err |=> seq_err) else $error("error flag cleared"); // R9

endmodule

// File: tb/sim_recfg_sequencer.sv
module sim_recfg_sequencer;

    localparam int NCH = 4;
    localparam int RST_CYC = 8;
    localparam int WDOG = 64;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [3:0] req = '0;
    logic [3:0] mode = '0;
    logic [3:0] ack;
    logic       txr = 1'b1;
    logic       rxr = 1'b1;
    logic       lnk = 1'b1;
    logic       busy = 1'b0;
    logic [1:0] ech;
    logic       stream;
    logic [0:0] img;
    logic       start;
    logic [3:0] drst;
    logic       err;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    recfg_sequencer #(.NCH(NCH), .NMODE(2), .RST_CYC(RST_CYC), .WDOG(WDOG)) u0 (
        .clk (clk), .rst (rst), .chan_req (req), .chan_mode (mode),
        .chan_ack (ack), .xcvr_tx_rdy (txr), .xcvr_rx_rdy (rxr),
        .link_up (lnk), .eng_busy (busy), .eng_chan (ech),
        .eng_stream_en (stream), .eng_img_sel (img), .eng_start (start),
        .chan_drst (drst), .seq_err (err)
    );

    task automatic chk(input bit ok, input string rq, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", rq, act, exp);
        end
    endtask

    // full sequence for channel ch; late >= 0 raises that request mid-sequence
    task automatic run_seq(input int ch, input int md, input int late, input bit exp_err);
        int  k = 0;
        bit  bad = 1'b0;
        bit  early = 1'b0;
        logic [3:0] oh = 4'(1) << ch;
        while (ack == 0 && k < 50) begin @(negedge clk); k++; end
        chk(ack == oh, "R2 grant", ack, oh);
        req[ch] = 1'b0;
        chk(ech == 2'(ch), "R3 chan", ech, ch);
        chk(img == 1'(md), "R3 image", img, md);
        chk(stream == 1'b1, "R3 stream", stream, 1);
        @(negedge clk);
        chk(start == 1'b1, "R4 start", start, 1);
        mode[ch] = ~1'(md);
        if (late >= 0) req[late] = 1'b1;
        @(negedge clk);
        chk(start == 1'b0, "R4 start end", start, 0);
        repeat (3) begin
            @(negedge clk);
            if (drst != 0) early = 1'b1;
        end
        chk(!early, "R5 no reset while busy low", early, 0);
        chk(ack == oh, "R2 late request ignored", ack, oh);
        busy = 1'b1;
        repeat (4) @(negedge clk);
        busy = 1'b0;
        @(negedge clk);
        chk(drst == oh, "R6 reset owner", drst, oh);
        chk(img == 1'(md), "R8 mode captured", img, md);
        k = 0;
        while (drst != 0 && k < 100) begin
            if (drst != oh) bad = 1'b1;
            lnk = 1'b0;
            k++;
            @(negedge clk);
        end
        chk(k == RST_CYC, "R6 reset length", k, RST_CYC);
        chk(!bad, "R6 reset one-hot", bad, 0);
        repeat (3) @(negedge clk);
        chk(ack == oh, "R7 hold until link", ack, oh);
        lnk = 1'b1;
        @(negedge clk);
        chk(ack == 4'b0, "R7 release", ack, 0);
        chk(err == exp_err, "R9 error flag", err, exp_err);
        mode[ch] = 1'(md);
    endtask

    task automatic t_reset;
        req = 4'b0001;
        repeat (3) @(negedge clk);
        chk(ack == 0, "R10 ack", ack, 0);
        chk(start == 0 && stream == 0, "R10 engine", {start, stream}, 0);
        chk(drst == 0, "R10 drst", drst, 0);
        chk(err == 0, "R10 err", err, 0);
        req = 4'b0000;
        rst = 1'b0;
        @(negedge clk);
    endtask

    task automatic t_gate;
        txr = 1'b0;
        req[2] = 1'b1;
        mode[2] = 1'b1;
        repeat (4) @(negedge clk);
        chk(ack == 0, "R1 tx not ready", ack, 0);
        txr = 1'b1; rxr = 1'b0;
        repeat (4) @(negedge clk);
        chk(ack == 0, "R1 rx not ready", ack, 0);
        rxr = 1'b1; busy = 1'b1;
        repeat (4) @(negedge clk);
        chk(ack == 0, "R1 engine busy", ack, 0);
        busy = 1'b0;
        run_seq(2, 1, -1, 1'b0);
    endtask

    task automatic t_priority;
        mode[1] = 1'b1; mode[3] = 1'b1; mode[0] = 1'b0;
        req = 4'b1010;
        run_seq(1, 1, 0, 1'b0);
        run_seq(0, 0, -1, 1'b0);
        run_seq(3, 1, -1, 1'b0);
    endtask

    task automatic t_watchdog;
        int  k = 0;
        bit  rs = 1'b0;
        req[2] = 1'b1;
        while (ack == 0 && k < 50) begin @(negedge clk); k++; end
        req[2] = 1'b0;
        k = 0;
        while (ack != 0 && k < 500) begin
            @(negedge clk);
            if (drst != 0) rs = 1'b1;
            k++;
        end
        chk(k == WDOG + 2, "R9 timeout cycles", k, WDOG + 2);
        chk(err == 1'b1, "R9 error set", err, 1);
        chk(!rs, "R5 no reset without busy", rs, 0);
        req[1] = 1'b1;
        mode[1] = 1'b0;
        run_seq(1, 0, -1, 1'b1);
    endtask

    initial begin
        t_reset;
        t_gate;
        t_priority;
        t_watchdog;
        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual hung expected finished");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

endmodule